// File: doc/BRIEF.md
# Conversion Pacing and Settling Sequencer

This block runs in the master-clock domain of a delta-sigma converter and decides when each conversion result is published. It counts master clocks to mark conversion periods. The period is `SLOW_CLKS` with the rate input low and `FAST_CLKS` with it high. At the end of each period it takes the raw word from the decimation filter. It subtracts a stored offset, saturates the result to 24 bits, and pulses `rdy` with the result.

Changing the channel, gain or rate inputs resets the modulator and filter. An overrange word also causes this reset, as do standby and power-down. After any of these resets the sequencer waits four full periods before it publishes again. A calibration request first shorts the inputs for four periods and stores the resulting offset word. It then settles for four more periods, so the next ready comes after eight periods. The states are SETTLE (counting settling periods), RUN (one result per period), CAL (inputs shorted, offset being measured) and STBY (everything held).

The transitions are as follows:
- Standby entry goes from any state to STBY.
- Standby exit goes from STBY to SETTLE, or to CAL when a calibration is pending.
- A configuration change goes from SETTLE or RUN to SETTLE, and restarts CAL from its beginning.
- A calibration request goes from SETTLE or RUN to CAL.
- The offset capture goes from CAL to SETTLE.
- The settled result goes from SETTLE to RUN.
- An overrange goes from RUN to SETTLE.

Top module: `adc_conv_seq`

## Requirements
- R1: A conversion period lasts P master clocks, where P is `FAST_CLKS` when `speed_fast`=1 and `SLOW_CLKS` when it is 0. In RUN, `rdy` pulses for exactly one cycle, once every P cycles.
- R2: A change on `chan_sel`, `gain_sel` or `speed_fast` drives `flt_rst` high in the cycle it is seen. The next `rdy` comes on the (4·P+1)-th rising edge after the change.
- R3: If a select input changes again while settling, the count restarts. The next `rdy` is timed from the last change alone, as in R2.
- R4: A step in the raw filter word does not reset anything. Results keep coming every P cycles and show the new value.
- R5: A one-cycle `cal_req` raises `short_inputs` for four periods. The raw word at the end of the fourth period is stored as the offset (saturated to 24 bits). The next `rdy` comes on the (8·P+1)-th rising edge after the request, and it and all later results carry raw minus offset.
- R6: `result` is a 24-bit two's-complement value. A corrected value above 0x7FFFFF gives 0x7FFFFF, and one below 0x800000 gives 0x800000; it never wraps.
- R7: A raw word above +`OVR_LIM` publishes 0x7FFFFF, and one below −`OVR_LIM` publishes 0x800000. Either one also resets the modulator and filter, so the next `rdy` follows 4·P cycles later (a quarter of the normal rate).
- R8: While `stby_req` is high, `flt_rst` stays high and no `rdy` occurs. After `stby_req` falls, the next `rdy` comes on the (4·P+1)-th rising edge.
- R9: A `cal_req` that arrives during standby is held. The calibration of R5 runs when standby ends, and the next `rdy` comes on the (8·P+1)-th rising edge after `stby_req` falls.
- R10: While `pwdn_n` is low, `rdy`=0, `flt_rst`=1 and `short_inputs`=0, and the stored offset returns to zero. The first `rdy` after release comes on the 4·P-th rising edge.
- R11: When a select change falls in the same cycle as a period end, no result is published for that period. Settling restarts as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master conversion clock |
| pwdn_n | input | 1 | Active-low power-down; resets the whole sequence |
| chan_sel | input | CH_W | Input channel select |
| gain_sel | input | 2 | Amplifier gain select |
| speed_fast | input | 1 | 1 selects the fast rate, 0 the slow rate |
| stby_req | input | 1 | Level request to hold in standby |
| cal_req | input | 1 | One-cycle request for offset calibration |
| flt_word | input | RAW_W | Signed raw decimation-filter word |
| flt_rst | output | 1 | Reset for the modulator and filter |
| short_inputs | output | 1 | Shorts the analog inputs during offset measurement |
| rdy | output | 1 | One-cycle pulse when a new result is valid |
| result | output | DW | Offset-corrected, saturated two's-complement result |

## Verification
A select-input change and a period end can fall in the same cycle. In that cycle, the result due at the period end competes with the reset that the change requires. The bench provokes this by changing a select exactly one cycle before the edge that would publish a RUN result. It then requires that no ready appears at that edge, since the scoreboard rejects any unexpected ready. It also requires that the next ready arrives 4·P+1 edges after the change.

// File: rtl/adc_conv_seq_pkg.sv
package adc_conv_seq_pkg;

    // number of conversion periods the filter needs after a reset
    localparam int SETTLE_N = 4;

    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,
        ST_RUN    = 2'd1,
        ST_CAL    = 2'd2,
        ST_STBY   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int SLOW_CLKS = 491520,
    parameter int FAST_CLKS = 61440
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_i,
    input  logic restart_i,
    input  logic hold_i,
    output logic period_end_o
);
    localparam int MAX_CLKS = (SLOW_CLKS > FAST_CLKS) ? SLOW_CLKS : FAST_CLKS;
    localparam int CNT_W    = $clog2(MAX_CLKS);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_CLKS - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt     = fast_i ? FAST_LAST : SLOW_LAST;
        period_end_o = !hold_i && (cnt_q == last_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i || hold_i || period_end_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R1
    end_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |=> !period_end_o);

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> !period_end_o);

endmodule

// File: rtl/adc_cfg_watch.sv
module adc_cfg_watch #(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_i,
    output logic             changed_o
);
    logic [CFG_W-1:0] cfg_q;
    logic             primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            cfg_q    <= cfg_i;
            primed_q <= 1'b1;
        end
    end

    assign changed_o = primed_q && (cfg_i != cfg_q);

endmodule

// File: rtl/adc_result_path.sv
module adc_result_path #(
    parameter int DW      = 24,
    parameter int RAW_W   = 26,
    parameter int OVR_LIM = 12582912
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [RAW_W-1:0] raw_i,
    input  logic                    capture_i,
    output logic                    ovr_o,
    output logic [DW-1:0]           value_o
);
    localparam int DIFF_W = RAW_W + 1;
    localparam logic signed [DIFF_W-1:0] POS_FS =
        {{(DIFF_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [DIFF_W-1:0] NEG_FS =
        {{(DIFF_W-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] POS_CODE = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_CODE = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [RAW_W-1:0] OVR_POS = RAW_W'(OVR_LIM);
    localparam logic signed [RAW_W-1:0] OVR_NEG = -OVR_POS;

    logic signed [DW-1:0]     off_q;
    logic signed [DIFF_W-1:0] raw_x;
    logic signed [DIFF_W-1:0] off_x;
    logic signed [DIFF_W-1:0] diff;
    logic                     ovr_hi;
    logic                     ovr_lo;

    function automatic logic [DW-1:0] clip_dw(input logic signed [DIFF_W-1:0] v);
        if (v > POS_FS) begin
            return POS_CODE;
        end else if (v < NEG_FS) begin
            return NEG_CODE;
        end else begin
            return v[DW-1:0];
        end
    endfunction

    always_comb begin
        raw_x  = {raw_i[RAW_W-1], raw_i};
        off_x  = {{(DIFF_W-DW){off_q[DW-1]}}, off_q};
        diff   = raw_x - off_x;
        ovr_hi = raw_i > OVR_POS;
        ovr_lo = raw_i < OVR_NEG;
        ovr_o  = ovr_hi || ovr_lo;
        if (ovr_hi) begin
            value_o = POS_CODE;
        end else if (ovr_lo) begin
            value_o = NEG_CODE;
        end else begin
            value_o = clip_dw(diff);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (capture_i) begin
            off_q <= clip_dw(raw_x);
        end
    end

    // R5
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_i |=> $stable(off_q));

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_conv_seq_pkg::*;
#(
    parameter int CH_W      = 2,
    parameter int SLOW_CLKS = 491520,
    parameter int FAST_CLKS = 61440,
    parameter int DW        = 24,
    parameter int RAW_W     = 26,
    parameter int OVR_LIM   = 12582912
) (
    input  logic                    clk,
    input  logic                    pwdn_n,
    input  logic [CH_W-1:0]         chan_sel,
    input  logic [1:0]              gain_sel,
    input  logic                    speed_fast,
    input  logic                    stby_req,
    input  logic                    cal_req,
    input  logic signed [RAW_W-1:0] flt_word,
    output logic                    flt_rst,
    output logic                    short_inputs,
    output logic                    rdy,
    output logic [DW-1:0]           result
);
    localparam int CFG_W = CH_W + 3;
    localparam int SC_W  = $clog2(SETTLE_N);
    localparam logic [SC_W-1:0] SC_LAST = SC_W'(SETTLE_N - 1);

    seq_state_e      state_q, state_d;
    logic [SC_W-1:0] sc_q, sc_d;
    logic            cal_pend_q, cal_pend_d;
    logic            restart, emit, capture;
    logic            period_end, cfg_chg, ovr;
    logic [DW-1:0]   value;
    logic            rdy_q;
    logic [DW-1:0]   res_q;

    adc_conv_timer #(
        .SLOW_CLKS (SLOW_CLKS),
        .FAST_CLKS (FAST_CLKS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (pwdn_n),
        .fast_i       (speed_fast),
        .restart_i    (restart),
        .hold_i       (state_q == ST_STBY),
        .period_end_o (period_end)
    );

    adc_cfg_watch #(
        .CFG_W (CFG_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (pwdn_n),
        .cfg_i     ({chan_sel, gain_sel, speed_fast}),
        .changed_o (cfg_chg)
    );

    adc_result_path #(
        .DW      (DW),
        .RAW_W   (RAW_W),
        .OVR_LIM (OVR_LIM)
    ) u_res (
        .clk       (clk),
        .rst_n     (pwdn_n),
        .raw_i     (flt_word),
        .capture_i (capture),
        .ovr_o     (ovr),
        .value_o   (value)
    );

    // next-state decision; priority: standby, config change, calibration, period end
    always_comb begin
        state_d    = state_q;
        sc_d       = sc_q;
        cal_pend_d = cal_pend_q;
        restart    = 1'b0;
        emit       = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_STBY: begin
                if (cal_req) begin
                    cal_pend_d = 1'b1;
                end
                if (!stby_req) begin
                    restart    = 1'b1;
                    sc_d       = '0;
                    cal_pend_d = 1'b0;
                    state_d    = (cal_pend_q || cal_req) ? ST_CAL : ST_SETTLE;
                end
            end
            ST_SETTLE, ST_RUN, ST_CAL: begin
                if (stby_req) begin
                    restart    = 1'b1;
                    sc_d       = '0;
                    cal_pend_d = cal_req;
                    state_d    = ST_STBY;
                end else if (cfg_chg) begin
                    restart = 1'b1;
                    sc_d    = '0;
                    state_d = (state_q == ST_CAL) ? ST_CAL : ST_SETTLE;
                end else if (cal_req && (state_q != ST_CAL)) begin
                    restart = 1'b1;
                    sc_d    = '0;
                    state_d = ST_CAL;
                end else if (period_end) begin
                    if (state_q == ST_RUN) begin
                        emit = 1'b1;
                        if (ovr) begin
                            restart = 1'b1;
                            sc_d    = '0;
                            state_d = ST_SETTLE;
                        end
                    end else if (sc_q == SC_LAST) begin
                        sc_d = '0;
                        if (state_q == ST_CAL) begin
                            capture = 1'b1;
                            restart = 1'b1;
                            state_d = ST_SETTLE;
                        end else begin
                            emit = 1'b1;
                            if (ovr) begin
                                restart = 1'b1;
                            end else begin
                                state_d = ST_RUN;
                            end
                        end
                    end else begin
                        sc_d = sc_q + SC_W'(1);
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge pwdn_n) begin
        if (!pwdn_n) begin
            state_q    <= ST_SETTLE;
            sc_q       <= '0;
            cal_pend_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            sc_q       <= sc_d;
            cal_pend_q <= cal_pend_d;
        end
    end

    // result register
    always_ff @(posedge clk or negedge pwdn_n) begin
        if (!pwdn_n) begin
            rdy_q <= 1'b0;
            res_q <= '0;
        end else begin
            rdy_q <= emit;
            if (emit) begin
                res_q <= value;
            end
        end
    end

    // outputs
    always_comb begin
        flt_rst      = !pwdn_n || restart || (state_q == ST_STBY);
        short_inputs = (state_q == ST_CAL);
        rdy          = rdy_q;
        result       = res_q;
    end

    // R1
    rdy_pulse_chk: assert property (@(posedge clk) disable iff (!pwdn_n)
        rdy |=> !rdy);

    // R8
    stby_quiet_chk: assert property (@(posedge clk) disable iff (!pwdn_n)
        (state_q == ST_STBY) |-> !rdy);

    // R5
    cal_quiet_chk: assert property (@(posedge clk) disable iff (!pwdn_n)
        short_inputs |-> !rdy);

    // R11
    cfg_drop_chk: assert property (@(posedge clk) disable iff (!pwdn_n)
        cfg_chg |=> !rdy);

    // R2
    cfg_reset_chk: assert property (@(posedge clk) disable iff (!pwdn_n)
        cfg_chg |-> flt_rst);

endmodule

// File: tb/adc_conv_seq_bench.sv
`timescale 1ns/1ps
module adc_conv_seq_bench;

    localparam int P  = 10;
    localparam int PS = 24;

    logic               clk = 1'b0;
    logic               pwdn_n;
    logic [1:0]         chan_sel;
    logic [1:0]         gain_sel;
    logic               speed_fast;
    logic               stby_req;
    logic               cal_req;
    logic signed [25:0] sig;
    logic signed [25:0] offv;
    logic signed [25:0] flt_word;
    logic               flt_rst;
    logic               short_inputs;
    logic               rdy;
    logic [23:0]        result;

    int cyc    = 0;
    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [23:0] val;
        int          at;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    // filter model: shorted inputs present the offset level
    assign flt_word = short_inputs ? offv : sig;

    adc_conv_seq #(
        .CH_W      (2),
        .SLOW_CLKS (PS),
        .FAST_CLKS (P)
    ) u_adc_conv_seq (
        .clk          (clk),
        .pwdn_n       (pwdn_n),
        .chan_sel     (chan_sel),
        .gain_sel     (gain_sel),
        .speed_fast   (speed_fast),
        .stby_req     (stby_req),
        .cal_req      (cal_req),
        .flt_word     (flt_word),
        .flt_rst      (flt_rst),
        .short_inputs (short_inputs),
        .rdy          (rdy),
        .result       (result)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [23:0] v, input int at, input string tag);
        exp_t e;
        e.val = v;
        e.at  = at;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (pwdn_n && rdy) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected rdy: actual %h at cycle %0d expected no result", result, cyc);
            end else begin
                e = exp_q.pop_front();
                if (result !== e.val || cyc != e.at) begin
                    n_fail++;
                    $display("FAIL %s: actual %h at cycle %0d expected %h at cycle %0d",
                             e.tag, result, cyc, e.val, e.at);
                end
            end
        end
    end

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int c;
        int last;
        pwdn_n     = 1'b0;
        chan_sel   = 2'd0;
        gain_sel   = 2'd0;
        speed_fast = 1'b1;
        stby_req   = 1'b0;
        cal_req    = 1'b0;
        sig        = 26'sd1000;
        offv       = 26'sd0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(rdy == 1'b0, "R10 rdy in power-down", rdy, 0);
        chk(flt_rst == 1'b1, "R10 flt_rst in power-down", flt_rst, 1);
        chk(short_inputs == 1'b0, "R10 short in power-down", short_inputs, 0);
        pwdn_n = 1'b1;
        c = cyc;
        push(24'd1000, c + 4*P, "R10 first after release");
        push(24'd1000, c + 5*P, "R1 run period");
        push(24'd1000, c + 6*P, "R1 run period");
        wait_to(c + 6*P + 1);

        // R2 single change
        chan_sel = 2'd1;
        #1;
        chk(flt_rst == 1'b1, "R2 flt_rst on change", flt_rst, 1);
        c = cyc;
        push(24'd1000, c + 4*P + 1, "R2 settle after change");
        wait_to(c + 3);
        chk(flt_rst == 1'b0, "R2 flt_rst released", flt_rst, 0);
        wait_to(c + 4*P + 2);

        // R3 change again during settling
        chan_sel = 2'd2;
        c = cyc;
        wait_to(c + 15);
        gain_sel = 2'd2;
        c = cyc;
        push(24'd1000, c + 4*P + 1, "R3 settle restarted");
        push(24'd1000, c + 5*P + 1, "R3 run after settle");
        wait_to(c + 5*P + 2);

        // R1 slow rate
        speed_fast = 1'b0;
        c = cyc;
        push(24'd1000, c + 4*PS + 1, "R1 slow settle");
        push(24'd1000, c + 5*PS + 1, "R1 slow period");
        wait_to(c + 5*PS + 2);
        speed_fast = 1'b1;
        c = cyc;
        push(24'd1000, c + 4*P + 1, "R1 back to fast");
        last = c + 4*P + 1;
        wait_to(last + 1);

        // R11 change in the cycle of a period end
        wait_to(last + P - 1);
        chan_sel = 2'd3;
        c = cyc;
        push(24'd1000, c + 4*P + 1, "R11 coincident change");
        last = c + 4*P + 1;
        wait_to(last + 1);

        // R4 input step, no reset
        sig = 26'sd5000;
        push(24'd5000, last + P, "R4 step value");
        push(24'd5000, last + 2*P, "R4 no settle gap");
        last = last + 2*P;
        wait_to(last + 1);

        // R5 calibration
        offv    = 26'sd300;
        sig     = 26'sd1000;
        cal_req = 1'b1;
        c = cyc;
        @(negedge clk);
        cal_req = 1'b0;
        wait_to(c + 4*P);
        chk(short_inputs == 1'b1, "R5 short during measure", short_inputs, 1);
        wait_to(c + 4*P + 1);
        chk(short_inputs == 1'b0, "R5 short released", short_inputs, 0);
        push(24'd700, c + 8*P + 1, "R5 first corrected");
        push(24'd700, c + 9*P + 1, "R5 offset kept");
        last = c + 9*P + 1;
        wait_to(last + 1);

        // R6 saturation of corrected value
        sig = -26'sd8388600;
        push(24'h800000, last + P, "R6 negative saturation");
        last = last + P;
        wait_to(last + 1);

        // R7 overrange clip and quarter rate
        sig = 26'sd20000000;
        push(24'h7FFFFF, last + P, "R7 positive clip");
        push(24'h7FFFFF, last + 5*P, "R7 quarter rate");
        wait_to(last + 5*P + 2);
        sig = 26'sd1000;
        push(24'd700, last + 9*P, "R7 recovery");
        last = last + 9*P;
        wait_to(last + 1);
        sig = -26'sd20000000;
        push(24'h800000, last + P, "R7 negative clip");
        wait_to(last + P + 1);
        sig = 26'sd1000;
        push(24'd700, last + 5*P, "R7 negative recovery");
        last = last + 5*P;
        wait_to(last + 1);

        // R8 standby
        stby_req = 1'b1;
        c = cyc;
        wait_to(c + 5);
        chk(flt_rst == 1'b1, "R8 flt_rst in standby", flt_rst, 1);
        wait_to(c + 30);
        stby_req = 1'b0;
        c = cyc;
        push(24'd700, c + 4*P + 1, "R8 settle after standby");
        wait_to(c + 4*P + 2);

        // R9 calibration requested during standby
        stby_req = 1'b1;
        c = cyc;
        wait_to(c + 5);
        offv    = -26'sd200;
        cal_req = 1'b1;
        @(negedge clk);
        cal_req = 1'b0;
        wait_to(c + 15);
        chk(short_inputs == 1'b0, "R9 no short while in standby", short_inputs, 0);
        stby_req = 1'b0;
        c = cyc;
        push(24'd1200, c + 8*P + 1, "R9 cal after standby");
        wait_to(c + 8*P + 2);

        // R10 power-down clears offset
        pwdn_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rdy == 1'b0, "R10 rdy cleared", rdy, 0);
        chk(flt_rst == 1'b1, "R10 flt_rst held", flt_rst, 1);
        pwdn_n = 1'b1;
        c = cyc;
        push(24'd1000, c + 4*P, "R10 offset cleared");
        wait_to(c + 4*P + 1);

        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule